// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits beside a flash array controller and watches the host's write cycles. Each write has already been turned into a single-cycle synchronous strobe that carries an address and a byte of data. The block recognises the six-write erase handshake. That handshake is two unlock writes, a setup write, two further unlock writes and a final command write. The block decodes it into a whole-device erase request or a one-sector erase request, each given to an erase engine as a single start pulse.

After a start, the block reports that it is busy until the engine signals completion. While it is busy it filters host writes. During a whole-device erase every write is dropped. During a sector erase only the suspend code gets through, and it comes out as a one-cycle suspend request. The engine preprograms to all-zero on its own, so the host never has to send a preprogram command.

A two-bit mode output tells the host which state the block is in: reading the array, part-way through a handshake, erasing the whole device, or erasing a sector. The sector number is taken from the upper address bits of the final write. It is held until the erase finishes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode is 0 (read array), busy is 0, both start pulses and the suspend request are 0, and the latched sector is 0.
- R2: The writes (addr 0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10), in that order, raise chip_erase_start for exactly the one cycle after the sixth write is sampled. From that same cycle busy is 1 and mode is 2 (whole-device erase). Only the low 11 address bits are compared.
- R3: The same five first writes followed by a write of data 0x30 at any address raise sector_erase_start for one cycle. In that cycle mode becomes 3 (sector erase) and erase_sector shows address bits [AW-1 : AW-SW] of that sixth write.
- R4: While one to five writes of a handshake have been matched and nothing is busy, mode is 1 (command window).
- R5: A write whose compared address or whose data differs from the value expected at the current step clears the handshake. Mode is 0 the next cycle, and a later final write alone starts nothing.
- R6: While a whole-device erase is busy, every write is ignored. Mode stays 2, no start pulse appears, and no suspend request appears, even for data 0xB0.
- R7: While a sector erase is busy, a write of data 0xB0 raises suspend_req for the next cycle only. Any other write has no effect, and mode stays 3.
- R8: A cycle with erase_done high while busy returns the block, on the next cycle, to mode 0 with busy 0 and erase_sector 0.
- R9: busy stays 1 from the start pulse until erase_done is seen, whatever is written meanwhile.
- R10: Cycles with wr_en low between the writes of a handshake do not disturb its progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| erase_done | input | 1 | Erase engine finished |
| mode | output | 2 | 0 read, 1 command window, 2 device erase, 3 sector erase |
| busy | output | 1 | Erase in progress |
| chip_erase_start | output | 1 | Whole-device erase start pulse |
| sector_erase_start | output | 1 | Sector erase start pulse |
| erase_sector | output | SW | Latched sector number |
| suspend_req | output | 1 | Suspend request pulse |

## Verification
Every result here is one register stage behind its cause. A write or done strobe is driven on a falling edge and sampled on the next rising edge. Its effect on mode, busy, the pulses and the sector must therefore be visible in the half-cycle after that rising edge. The bench checks each result at the falling edge that ends the strobe. For pulses it also checks one cycle later that they have dropped again. The sweeps cover every sector number, a mismatch at every step in both address and data, and filtered writes of every command code during both kinds of erase.

// File: rtl/fcd_pkg.sv
// Shared types for the flash erase command decoder.
// Assumes: mode encoding is visible at the top-level port and must stay stable.
package fcd_pkg;
    typedef enum logic [1:0] {
        MODE_READ   = 2'd0,
        MODE_CMD    = 2'd1,
        MODE_CHIP   = 2'd2,
        MODE_SECTOR = 2'd3
    } fcd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHIP   = 2'd1,
        ST_SECTOR = 2'd2
    } fcd_state_e;
endpackage

// File: rtl/fcd_seq_matcher.sv
// Step counter for the six-write erase handshake.
// Compares each write against the expected pair for the current step and
// flags a completed device or sector request on the sixth write.
// Assumes: hold is high whenever an erase runs; the counter is forced to zero then.
module fcd_seq_matcher #(
    parameter int          CMD_AW   = 11,
    parameter logic [10:0] UNL_A1   = 11'h555,
    parameter logic [7:0]  UNL_D1   = 8'hAA,
    parameter logic [10:0] UNL_A2   = 11'h2AA,
    parameter logic [7:0]  UNL_D2   = 8'h55,
    parameter logic [7:0]  SETUP_D  = 8'h80,
    parameter logic [7:0]  CHIP_D   = 8'h10,
    parameter logic [7:0]  SECTOR_D = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [7:0]        data,
    input  logic              hold,
    output logic              hit_chip,
    output logic              hit_sector,
    output logic              in_progress
);
    localparam int STEPS  = 6;
    localparam int LAST   = STEPS - 1;
    localparam int STEP_W = $clog2(STEPS);

    logic [STEP_W-1:0] step_q;
    logic [CMD_AW-1:0] exp_addr;
    logic [7:0]        exp_data;
    logic              step_ok;

    // Expected address/data pair for the current step.
    always_comb begin
        unique case (step_q)
            3'd0, 3'd3: begin exp_addr = UNL_A1; exp_data = UNL_D1;  end
            3'd1, 3'd4: begin exp_addr = UNL_A2; exp_data = UNL_D2;  end
            3'd2:       begin exp_addr = UNL_A1; exp_data = SETUP_D; end
            default:    begin exp_addr = UNL_A1; exp_data = CHIP_D;  end
        endcase
    end

    // Match of an early step, and decode of the final command write.
    always_comb begin
        step_ok    = (addr_lo == exp_addr) && (data == exp_data);
        hit_chip   = wr_en && !hold && (step_q == STEP_W'(LAST)) &&
                     (addr_lo == UNL_A1) && (data == CHIP_D);
        hit_sector = wr_en && !hold && (step_q == STEP_W'(LAST)) &&
                     (data == SECTOR_D);
    end

    // Advance on a matching write, clear on a mismatch, completion or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            step_q <= '0;
        end else if (wr_en) begin
            if (step_q != STEP_W'(LAST) && step_ok) begin
                step_q <= step_q + 1'b1;
            end else begin
                step_q <= '0;
            end
        end
    end

    assign in_progress = (step_q != '0);

    p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_W'(LAST));
    p_hold_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (step_q == '0));
    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hold) |=> $stable(step_q));
endmodule

// File: rtl/fcd_sector_latch.sv
// Holds the sector number of a sector erase until the erase completes.
// Assumes: load and clear never coincide (load only happens while idle).
module fcd_sector_latch #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    input  logic [SW-1:0] sector_in,
    output logic [SW-1:0] sector_q
);
    // Capture on load, release on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sector_q <= '0;
        end else if (load) begin
            sector_q <= sector_in;
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sector_q == '0));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (sector_q == $past(sector_in)));
endmodule

// File: rtl/fcd_mode_ctrl.sv
// Operation state machine: turns decoded requests into start pulses,
// keeps busy until the engine reports done, filters writes while busy
// and passes only the suspend code during a sector erase.
// Assumes: erase_done is only meaningful while busy; it is ignored when idle.
module fcd_mode_ctrl #(
    parameter logic [7:0] SUSP_D = 8'hB0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       data,
    input  logic             hit_chip,
    input  logic             hit_sector,
    input  logic             in_progress,
    input  logic             erase_done,
    output fcd_pkg::fcd_mode_e mode,
    output logic             busy,
    output logic             chip_start,
    output logic             sector_start,
    output logic             suspend_req,
    output logic             finish
);
    import fcd_pkg::*;

    fcd_state_e state_q;

    // Operation state: idle until a request, busy until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hit_chip)        state_q <= ST_CHIP;
                    else if (hit_sector) state_q <= ST_SECTOR;
                end
                default: begin
                    if (erase_done)      state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // One-cycle start and suspend pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_start   <= 1'b0;
            sector_start <= 1'b0;
            suspend_req  <= 1'b0;
        end else begin
            chip_start   <= (state_q == ST_IDLE) && hit_chip;
            sector_start <= (state_q == ST_IDLE) && hit_sector && !hit_chip;
            suspend_req  <= (state_q == ST_SECTOR) && wr_en &&
                            (data == SUSP_D) && !erase_done;
        end
    end

    // Mode and busy seen by the host.
    always_comb begin
        busy   = (state_q != ST_IDLE);
        finish = busy && erase_done;
        unique case (state_q)
            ST_CHIP:   mode = MODE_CHIP;
            ST_SECTOR: mode = MODE_SECTOR;
            default:   mode = in_progress ? MODE_CMD : MODE_READ;
        endcase
    end

    p_start_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_start && sector_start));
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !erase_done) |=> busy);
    p_done_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && erase_done) |=> (mode == MODE_READ));
    p_suspend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> ($past(wr_en) && $past(data) == SUSP_D));
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_start |=> !chip_start);
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash erase command decoder.
// Splits the write address into the compared low bits and the sector bits,
// and wires the step matcher, the operation state machine and the sector latch.
// Assumes: writes are single-cycle strobes already synchronised to clk.
module flash_cmd_decoder #(
    parameter int          AW       = 16,
    parameter int          SECTORS  = 8,
    parameter int          CMD_AW   = 11,
    parameter logic [10:0] UNL_A1   = 11'h555,
    parameter logic [7:0]  UNL_D1   = 8'hAA,
    parameter logic [10:0] UNL_A2   = 11'h2AA,
    parameter logic [7:0]  UNL_D2   = 8'h55,
    parameter logic [7:0]  SETUP_D  = 8'h80,
    parameter logic [7:0]  CHIP_D   = 8'h10,
    parameter logic [7:0]  SECTOR_D = 8'h30,
    parameter logic [7:0]  SUSP_D   = 8'hB0,
    localparam int         SW       = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          erase_done,
    output logic [1:0]    mode,
    output logic          busy,
    output logic          chip_erase_start,
    output logic          sector_erase_start,
    output logic [SW-1:0] erase_sector,
    output logic          suspend_req
);
    import fcd_pkg::*;

    logic               hit_chip;
    logic               hit_sector;
    logic               in_progress;
    logic               finish;
    fcd_mode_e          mode_e;

    fcd_seq_matcher #(
        .CMD_AW(CMD_AW), .UNL_A1(UNL_A1), .UNL_D1(UNL_D1),
        .UNL_A2(UNL_A2), .UNL_D2(UNL_D2), .SETUP_D(SETUP_D),
        .CHIP_D(CHIP_D), .SECTOR_D(SECTOR_D)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr_lo(wr_addr[CMD_AW-1:0]), .data(wr_data), .hold(busy),
        .hit_chip(hit_chip), .hit_sector(hit_sector), .in_progress(in_progress)
    );

    fcd_mode_ctrl #(.SUSP_D(SUSP_D)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .data(wr_data),
        .hit_chip(hit_chip), .hit_sector(hit_sector),
        .in_progress(in_progress), .erase_done(erase_done),
        .mode(mode_e), .busy(busy), .chip_start(chip_erase_start),
        .sector_start(sector_erase_start), .suspend_req(suspend_req),
        .finish(finish)
    );

    fcd_sector_latch #(.SW(SW)) u_sector (
        .clk(clk), .rst_n(rst_n),
        .load(hit_sector && !busy && !hit_chip), .clear(finish),
        .sector_in(wr_addr[AW-1 -: SW]), .sector_q(erase_sector)
    );

    assign mode = mode_e;

    p_busy_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mode == 2'd2 || mode == 2'd3));
    p_chip_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !erase_done) |=> (mode == 2'd2 && !suspend_req));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 16;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          erase_done = 1'b0;
    logic [1:0]    mode;
    logic          busy, chip_erase_start, sector_erase_start, suspend_req;
    logic [SW-1:0] erase_sector;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_done(erase_done), .mode(mode), .busy(busy),
        .chip_erase_start(chip_erase_start), .sector_erase_start(sector_erase_start),
        .erase_sector(erase_sector), .suspend_req(suspend_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one write strobe; returns at the falling edge after it was sampled.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    function automatic logic [AW-1:0] step_addr(input int s);
        return (s == 1 || s == 4) ? 16'h02AA : 16'h0555;
    endfunction

    function automatic logic [7:0] step_data(input int s);
        case (s)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    task automatic prefix(input int n, input int gap);
        for (int s = 0; s < n; s++) begin
            wr(step_addr(s), step_data(s));
            check("R4 command window mode", mode, 1);
            idle(gap);
        end
    endtask

    initial begin
        #(200_000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 busy", busy, 0);
        check("R1 starts", {chip_erase_start, sector_erase_start, suspend_req}, 0);
        check("R1 sector", erase_sector, 0);

        // R2 chip erase, with and without gaps (R10), upper address bits ignored
        for (int g = 0; g < 3; g++) begin
            prefix(5, g);
            wr(16'h0555 | (16'(g) << 13), 8'h10);
            check("R2 chip start", chip_erase_start, 1);
            check("R2 busy", busy, 1);
            check("R2 mode", mode, 2);
            check("R2 no sector start", sector_erase_start, 0);
            idle(1);
            check("R2 start is one cycle", chip_erase_start, 0);
            // R6 writes ignored during device erase
            for (int k = 0; k < 6; k++) begin
                wr(step_addr(k), step_data(k));
                check("R6 mode held", mode, 2);
            end
            wr(16'h0555, 8'hB0);
            check("R6 no suspend", suspend_req, 0);
            wr(16'h0000, 8'h30);
            check("R6 no sector start", sector_erase_start, 0);
            check("R9 busy held", busy, 1);
            pulse_done();
            check("R8 mode read", mode, 0);
            check("R8 busy low", busy, 0);
        end

        // R3 sector erase for every sector, R7 filtering and suspend
        for (int sec = 0; sec < 8; sec++) begin
            prefix(5, sec % 2);
            wr((16'(sec) << 13) | 16'h0123, 8'h30);
            check("R3 sector start", sector_erase_start, 1);
            check("R3 mode", mode, 3);
            check("R3 sector number", erase_sector, sec);
            check("R3 no chip start", chip_erase_start, 0);
            idle(1);
            check("R3 start is one cycle", sector_erase_start, 0);
            wr(16'h0555, 8'hAA);
            check("R7 other write no suspend", suspend_req, 0);
            wr(16'h0555, 8'h10);
            check("R7 chip code ignored", {chip_erase_start, mode}, 3);
            wr(16'h1234, 8'hB0);
            check("R7 suspend pulse", suspend_req, 1);
            check("R7 mode held", mode, 3);
            idle(1);
            check("R7 suspend one cycle", suspend_req, 0);
            check("R9 busy held", busy, 1);
            check("R3 sector held", erase_sector, sec);
            pulse_done();
            check("R8 mode read", mode, 0);
            check("R8 sector cleared", erase_sector, 0);
            check("R8 busy low", busy, 0);
        end

        // R5 mismatch at every step, in data and in address
        for (int s = 0; s < 6; s++) begin
            for (int kind = 0; kind < 2; kind++) begin
                prefix(s, 0);
                if (kind == 0) wr(step_addr(s), step_data(s) ^ 8'hFF);
                else           wr(step_addr(s) ^ 16'h0001, step_data(s));
                check("R5 mode read after mismatch", mode, 0);
                wr(16'h0555, 8'h10);
                check("R5 no chip start", chip_erase_start, 0);
                wr(16'h0000, 8'h30);
                check("R5 no sector start", sector_erase_start, 0);
                check("R5 not busy", busy, 0);
            end
        end

        // R8 done while idle has no effect
        pulse_done();
        check("R8 idle done ignored", mode, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule